// File: doc/BRIEF.md
# Mode-Switchable Two-Port Memory

This block is a 256-word by 32-bit synchronous memory with two ports. Each port has its own clock and its own reset, address, write data, byte mask and write enable, and each port returns registered read data. A one-bit configuration input selects between two behaviours. In simple configuration, port A is a write-only port and port B is a read-only port. In full configuration, both ports can read and write independently, each on its own clock.

A port registers its read result on the rising edge of its clock. It commits a write on the falling edge of its clock. A read issued on the rising edge that follows a write by the same port therefore returns the new data.

Each port's storage and control are clocked only by that port's clock. Two banks are used, one written only by port A and one written only by port B. A per-lane live-value table records which bank holds the newest copy of each byte. There is no handshake: a port acts on every edge of its clock. The control pins are plain levels, with no valid/ready pairing.

Top module: `mrdp_ram`

## Requirements
- R1: With `mode`=0 (simple), a word written through port A is returned on `b_rdata` by a port B read of the same address.
- R2: With `mode`=0, asserting `b_we` has no effect on the stored contents.
- R3: With `mode`=0, `a_rdata` is zero after every rising edge of `clk_a`.
- R4: With `mode`=1 (full), data written by either port is read back correctly by the other port.
- R5: A write changes only the byte lanes whose mask bit is set, where mask bit i covers data bits 8i+7 down to 8i. The other lanes keep their previous contents.
- R6: When `b_re` is low at a rising edge of `clk_b`, `b_rdata` keeps its previous value.
- R7: A port that writes an address on a falling edge and reads the same address on the next rising edge receives the newly written word.
- R8: If port B commits a write while port A presents a write enable to the same address, port B's write is dropped and port A's data is stored.
- R9: Changing `mode` while both write enables are low leaves the stored contents unchanged.
- R10: While a port's active-low reset is asserted, that port's read data is zero.
- R11: A falling edge with the write enable low changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock. Reads on the rising edge, writes on the falling edge. |
| rst_a_n | input | 1 | Port A asynchronous active-low reset |
| mode | input | 1 | 0 = simple (A writes, B reads), 1 = full (both ports read and write) |
| a_addr | input | 8 | Port A word address |
| a_wdata | input | 32 | Port A write data |
| a_be | input | 4 | Port A byte-lane write mask |
| a_we | input | 1 | Port A write enable |
| a_rdata | output | 32 | Port A registered read data |
| clk_b | input | 1 | Port B clock. Reads on the rising edge, writes on the falling edge. |
| rst_b_n | input | 1 | Port B asynchronous active-low reset |
| b_addr | input | 8 | Port B word address |
| b_wdata | input | 32 | Port B write data |
| b_be | input | 4 | Port B byte-lane write mask |
| b_we | input | 1 | Port B write enable (full configuration only) |
| b_re | input | 1 | Port B read enable |
| b_rdata | output | 32 | Port B registered read data |

## Verification
The checker assumes that `mode` is steady at any rising edge of `clk_a` where `a_we` is high. This follows from the rule that the configuration moves only while both ports are idle. The stimulus changes `mode` only between operations, after both write enables have been released. It also keeps the two ports from targeting one address at the same time, except in the single directed collision case. In that case, port A's enable is held across port B's falling edge so that the drop rule applies.

// File: rtl/mrdp_pkg.sv
package mrdp_pkg;
  typedef enum logic {
    MODE_SIMPLE = 1'b0,
    MODE_FULL   = 1'b1
  } mrdp_mode_e;
endpackage

// File: rtl/mrdp_bank.sv
// Storage bank with one write port (falling edge) and two combinational read taps.
module mrdp_bank #(
  parameter int DEPTH  = 256,
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES-1:0]        be,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr_p,
  input  logic [AW-1:0]           raddr_q,
  output logic [LANES*LANE_W-1:0] rdata_p,
  output logic [LANES*LANE_W-1:0] rdata_q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(negedge clk) begin
      if (we && be[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata_p[g*LANE_W +: LANE_W] = store[raddr_p];
    assign rdata_q[g*LANE_W +: LANE_W] = store[raddr_q];
  end
endmodule

// File: rtl/mrdp_lvt.sv
// One half of an XOR live-value table. A lane's live bank is the XOR of both halves.
// The A half copies the peer bit (live = 0, bank A); the B half inverts it (live = 1, bank B).
module mrdp_lvt #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter bit FLIP  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [LANES-1:0] be,
  input  logic [LANES-1:0] peer_bits,
  input  logic [AW-1:0]    raddr_p,
  input  logic [AW-1:0]    raddr_q,
  output logic [LANES-1:0] bits_p,
  output logic [LANES-1:0] bits_q
);
  logic [LANES-1:0] tag [DEPTH];

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tag[i] <= '0;
    end else if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (be[l]) tag[waddr][l] <= peer_bits[l] ^ FLIP;
      end
    end
  end

  assign bits_p = tag[raddr_p];
  assign bits_q = tag[raddr_q];
endmodule

// File: rtl/mrdp_rdport.sv
// Registered read output, updated on the rising edge of the port clock.
module mrdp_rdport #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          force_zero,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (force_zero) q <= '0;
    else if (en)         q <= din;
  end
endmodule

// File: rtl/mrdp_ram.sv
module mrdp_ram
  import mrdp_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int AW     = $clog2(DEPTH),
  parameter int DW     = LANES * LANE_W
) (
  input  logic             clk_a,
  input  logic             rst_a_n,
  input  logic             mode,
  input  logic [AW-1:0]    a_addr,
  input  logic [DW-1:0]    a_wdata,
  input  logic [LANES-1:0] a_be,
  input  logic             a_we,
  output logic [DW-1:0]    a_rdata,
  input  logic             clk_b,
  input  logic             rst_b_n,
  input  logic [AW-1:0]    b_addr,
  input  logic [DW-1:0]    b_wdata,
  input  logic [LANES-1:0] b_be,
  input  logic             b_we,
  input  logic             b_re,
  output logic [DW-1:0]    b_rdata
);
  logic full_mode;
  logic a_bank_we, b_bank_we;
  logic b_hit_a;

  assign full_mode = (mrdp_mode_e'(mode) == MODE_FULL);
  assign b_hit_a   = a_we && (a_addr == b_addr);
  assign a_bank_we = a_we;
  assign b_bank_we = full_mode && b_we && !b_hit_a;

  // bank contents seen at each port's address
  logic [DW-1:0] bank_a_at_a, bank_a_at_b, bank_b_at_a, bank_b_at_b;
  logic [LANES-1:0] lvt_a_at_a, lvt_a_at_b, lvt_b_at_a, lvt_b_at_b;

  mrdp_bank #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_bank_a (
    .clk(clk_a), .we(a_bank_we), .waddr(a_addr), .be(a_be), .wdata(a_wdata),
    .raddr_p(a_addr), .raddr_q(b_addr), .rdata_p(bank_a_at_a), .rdata_q(bank_a_at_b)
  );

  mrdp_bank #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_bank_b (
    .clk(clk_b), .we(b_bank_we), .waddr(b_addr), .be(b_be), .wdata(b_wdata),
    .raddr_p(a_addr), .raddr_q(b_addr), .rdata_p(bank_b_at_a), .rdata_q(bank_b_at_b)
  );

  mrdp_lvt #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .FLIP(1'b0)) u_lvt_a (
    .clk(clk_a), .rst_n(rst_a_n), .we(a_bank_we), .waddr(a_addr), .be(a_be),
    .peer_bits(lvt_b_at_a), .raddr_p(a_addr), .raddr_q(b_addr),
    .bits_p(lvt_a_at_a), .bits_q(lvt_a_at_b)
  );

  mrdp_lvt #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .FLIP(1'b1)) u_lvt_b (
    .clk(clk_b), .rst_n(rst_b_n), .we(b_bank_we), .waddr(b_addr), .be(b_be),
    .peer_bits(lvt_a_at_b), .raddr_p(a_addr), .raddr_q(b_addr),
    .bits_p(lvt_b_at_a), .bits_q(lvt_b_at_b)
  );

  // per-lane selection of the newest copy
  logic [DW-1:0] a_word, b_word;
  for (genvar g = 0; g < LANES; g++) begin : g_sel
    logic a_from_b, b_from_b;
    assign a_from_b = lvt_a_at_a[g] ^ lvt_b_at_a[g];
    assign b_from_b = lvt_a_at_b[g] ^ lvt_b_at_b[g];
    assign a_word[g*LANE_W +: LANE_W] = a_from_b ? bank_b_at_a[g*LANE_W +: LANE_W]
                                                 : bank_a_at_a[g*LANE_W +: LANE_W];
    assign b_word[g*LANE_W +: LANE_W] = b_from_b ? bank_b_at_b[g*LANE_W +: LANE_W]
                                                 : bank_a_at_b[g*LANE_W +: LANE_W];
  end

  mrdp_rdport #(.DW(DW)) u_rd_a (
    .clk(clk_a), .rst_n(rst_a_n), .en(1'b1), .force_zero(!full_mode),
    .din(a_word), .q(a_rdata)
  );

  mrdp_rdport #(.DW(DW)) u_rd_b (
    .clk(clk_b), .rst_n(rst_b_n), .en(b_re), .force_zero(1'b0),
    .din(b_word), .q(b_rdata)
  );
endmodule

// File: rtl/mrdp_ram_chk.sv
module mrdp_ram_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk_a,
  input logic          rst_a_n,
  input logic          clk_b,
  input logic          rst_b_n,
  input logic          mode,
  input logic          a_we,
  input logic [AW-1:0] a_addr,
  input logic [DW-1:0] a_rdata,
  input logic          b_we,
  input logic          b_re,
  input logic [AW-1:0] b_addr,
  input logic [DW-1:0] b_rdata,
  input logic          b_bank_we
);
  // R3: simple configuration forces port A read data to zero
  p_a_zero_r3: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !mode |=> (a_rdata == '0));

  // R6: port B read data holds while its read enable is low
  p_b_hold_r6: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    !b_re |=> $stable(b_rdata));

  // R2: no port B bank write in simple configuration
  p_b_quiet_r2: assert property (@(negedge clk_b) disable iff (!rst_b_n)
    (!mode && b_we) |-> !b_bank_we);

  // R8: port B write dropped when port A targets the same address
  p_collide_r8: assert property (@(negedge clk_b) disable iff (!rst_b_n)
    (b_we && a_we && a_addr == b_addr) |-> !b_bank_we);

  // R9: configuration is steady while port A writes
  p_mode_steady_r9: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    a_we |-> $stable(mode));
endmodule

bind mrdp_ram mrdp_ram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_a(clk_a), .rst_a_n(rst_a_n), .clk_b(clk_b), .rst_b_n(rst_b_n),
  .mode(mode), .a_we(a_we), .a_addr(a_addr), .a_rdata(a_rdata),
  .b_we(b_we), .b_re(b_re), .b_addr(b_addr), .b_rdata(b_rdata),
  .b_bank_we(b_bank_we)
);

// File: tb/mrdp_ram_tb_top.sv
module mrdp_ram_tb_top;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NB = 4;
  localparam int DEPTH = 256;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  always #4 clk_a = ~clk_a;
  initial begin
    #2;
    forever #4 clk_b = ~clk_b;
  end

  logic rst_a_n = 1'b0, rst_b_n = 1'b0, mode = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [NB-1:0] a_be = '0, b_be = '0;
  logic a_we = 1'b0, b_we = 1'b0, b_re = 1'b0;
  logic [DW-1:0] a_rdata, b_rdata;

  mrdp_ram dut_i (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .mode(mode), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_be(a_be), .a_we(a_we), .a_rdata(a_rdata),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_be(b_be), .b_we(b_we), .b_re(b_re), .b_rdata(b_rdata)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [DEPTH];

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                          logic [NB-1:0] be);
    logic [DW-1:0] r = old_w;
    for (int l = 0; l < NB; l++) if (be[l]) r[l*8 +: 8] = new_w[l*8 +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] pattern(int i);
    return (32'h9E3779B9 * (i + 1)) ^ 32'h00C0FFEE;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // port A write, then same-address read on the following rising edge
  task automatic wr_a(logic [AW-1:0] ad, logic [DW-1:0] d, logic [NB-1:0] be, string req);
    @(posedge clk_a); #1;
    a_addr = ad; a_wdata = d; a_be = be; a_we = 1'b1;
    @(negedge clk_a); #1;
    a_we = 1'b0;
    model[ad] = merge(model[ad], d, be);
    @(posedge clk_a); #1;
    chk(req, a_rdata, mode ? model[ad] : '0);
  endtask

  task automatic wr_b(logic [AW-1:0] ad, logic [DW-1:0] d, logic [NB-1:0] be, string req);
    @(posedge clk_b); #1;
    b_addr = ad; b_wdata = d; b_be = be; b_we = 1'b1; b_re = 1'b1;
    @(negedge clk_b); #1;
    b_we = 1'b0;
    if (mode) model[ad] = merge(model[ad], d, be);
    @(posedge clk_b); #1;
    chk(req, b_rdata, model[ad]);
    b_re = 1'b0;
  endtask

  task automatic rd_a(logic [AW-1:0] ad, string req);
    @(posedge clk_a); #1;
    a_addr = ad;
    @(posedge clk_a); #1;
    chk(req, a_rdata, mode ? model[ad] : '0);
  endtask

  task automatic rd_b(logic [AW-1:0] ad, string req);
    @(posedge clk_b); #1;
    b_addr = ad; b_re = 1'b1;
    @(posedge clk_b); #1;
    chk(req, b_rdata, model[ad]);
    b_re = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R10: reset state
    repeat (3) @(posedge clk_a);
    #1;
    chk("R10 a_rdata in reset", a_rdata, '0);
    chk("R10 b_rdata in reset", b_rdata, '0);
    rst_a_n = 1'b1; rst_b_n = 1'b1;

    // fill through port A in simple configuration (R3 checked on each write)
    for (int i = 0; i < DEPTH; i++) wr_a(i[AW-1:0], pattern(i), 4'hF, "R3 a_rdata zero");

    // R1: port B reads what A wrote
    rd_b(8'h00, "R1 simple read"); rd_b(8'h7F, "R1 simple read"); rd_b(8'hFF, "R1 simple read");
    // R2: port B write ignored
    wr_b(8'h10, 32'hDEADBEEF, 4'hF, "R2 b write ignored");
    rd_b(8'h10, "R2 b write ignored");
    // R3
    rd_a(8'h22, "R3 a_rdata zero");

    // R9: switch to full while idle; contents preserved
    mode = 1'b1;
    rd_a(8'h22, "R9 after mode change");
    rd_b(8'h80, "R9 after mode change");

    // R7 and R4
    wr_a(8'h30, 32'h11223344, 4'hF, "R7 A read-after-write");
    rd_b(8'h30, "R4 B sees A write");
    wr_b(8'h31, 32'hA5A55A5A, 4'hF, "R7 B read-after-write");
    rd_a(8'h31, "R4 A sees B write");

    // R5: byte masks on both ports
    wr_a(8'h40, 32'hCAFEF00D, 4'b0101, "R5 A lane mask");
    rd_b(8'h40, "R5 A lane mask");
    wr_b(8'h40, 32'h12345678, 4'b1000, "R5 B lane mask");
    rd_a(8'h40, "R5 B lane mask");

    // R11: write enable low changes nothing
    @(posedge clk_a); #1;
    a_addr = 8'h50; a_wdata = 32'h0BADF00D; a_be = 4'hF; a_we = 1'b0;
    @(negedge clk_a); #1;
    rd_b(8'h50, "R11 no write without enable");

    // R6: B read data holds when read enable low
    rd_b(8'h60, "R6 hold setup");
    @(posedge clk_b); #1;
    b_addr = 8'h61; b_re = 1'b0;
    repeat (2) @(posedge clk_b);
    #1;
    chk("R6 b_rdata hold", b_rdata, model[8'h60]);

    // R8: collision, A enable held across B falling edge
    @(posedge clk_a); #1;
    a_addr = 8'h70; a_wdata = 32'hAAAA0001; a_be = 4'hF; a_we = 1'b1;
    @(posedge clk_b); #1;
    b_addr = 8'h70; b_wdata = 32'hBBBB0002; b_be = 4'hF; b_we = 1'b1;
    @(negedge clk_b); #1;
    b_we = 1'b0; a_we = 1'b0;
    model[8'h70] = 32'hAAAA0001;
    rd_b(8'h70, "R8 A wins collision");
    rd_a(8'h70, "R8 A wins collision");

    // constrained random traffic in full configuration
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] ad = AW'($urandom % DEPTH);
      logic [DW-1:0] d  = $urandom;
      logic [NB-1:0] be = NB'($urandom);
      case ($urandom % 4)
        0: wr_a(ad, d, be, "R4 random A write");
        1: wr_b(ad, d, be, "R4 random B write");
        2: rd_a(ad, "R4 random A read");
        default: rd_b(ad, "R4 random B read");
      endcase
    end

    // R9: back to simple, contents preserved
    mode = 1'b0;
    for (int k = 0; k < 8; k++) rd_b(AW'(k * 31), "R9 back to simple");
    rd_a(8'h05, "R3 a_rdata zero again");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule